// File: doc/BRIEF.md
# Selectable Payload Pattern Generator

This block produces the payload of outgoing frames for a frame builder, one 64-bit beat at a time. At the start of every frame the caller selects one of four content sources: all zeros, pseudo-random bytes, a 64-byte programmable pattern that repeats, or a byte-counting sequence. The caller can also ask for a 32-bit serial number to be placed at the head of the payload. The caller supplies the serial number. Its value usually goes up by one for each frame.

The caller pulses a start strobe to open a payload. It then raises a beat request each time it consumes the current word. While the request is low the generator holds still, so backpressure from downstream passes straight through. The generator has no notion of payload length, and the caller simply stops requesting when the frame is complete. Software fills the pattern store one byte at a time through a small write port.

Top module: `payload_gen`

## Requirements
- R1: After reset, and before any start pulse, `payloadWord` is all zeros. The pattern store is also cleared to zero.
- R2: In mode 0 (zero), every payload byte that is not stamped is 0x00.
- R3: In mode 1 (random), lane k of the word carries bits [8k+7:8k] of a 64-bit LFSR. The LFSR loads the seed (default 64'h0123456789ABCDEF) on reset and is never reloaded. On each advancing beat it shifts left, and its new bit 0 is the XOR of bits 63, 62, 60 and 59. Its state is never zero.
- R4: Byte lane k of beat b holds payload offset 8b+k, and lane 0 sits in bits [7:0]. In mode 2 (pattern), the byte at offset p is pattern byte (p mod 64), so the pattern repeats every eight beats.
- R5: In mode 3 (sequence), the byte at offset p equals p mod 256. It wraps from 255 to 0 at beat 32.
- R6: When stamping is on, payload bytes 0..3 of beat 0 carry the serial number most-significant byte first (byte 0 is serial[31:24]). The selected mode still applies from offset 4 onward. A beat that wraps back to index 0 later in the same frame is not stamped.
- R7: The mode, the stamp enable and the serial number are captured only on the start pulse. Changing them in the middle of a frame has no effect on the output.
- R8: With no beat request and no start pulse, the word, the beat position and the LFSR hold. A pattern write is the one exception.
- R9: A start pulse resets the beat position to 0, so beat 0 appears on the cycle after the pulse. When a start pulse and a beat request arrive together, the start pulse wins and neither the position nor the LFSR advances.
- R10: A pattern write stores `patWrData` at byte address `patWrAddr`. The new byte appears in the output from the next cycle, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sopPulse | input | 1 | Opens a new payload and captures mode and serial settings |
| beatReq | input | 1 | Current beat consumed; advance to the next one |
| modeSel | input | 2 | Content source: 0 zero, 1 random, 2 pattern, 3 sequence |
| serialEn | input | 1 | Stamp the serial number into payload bytes 0..3 |
| serialVal | input | 32 | Serial number for the frame being opened |
| patWrEn | input | 1 | Pattern store byte write strobe |
| patWrAddr | input | 6 | Pattern store byte address |
| patWrData | input | 8 | Pattern store byte data |
| payloadWord | output | 64 | Current payload beat, lane 0 in bits [7:0] |

## Verification
Sequence frames longer than 32 beats check the wrap from 255 to 0. A design that sized its counter wrongly would emit 256 or a stale value there, and one that keyed stamping on the beat index would write the serial number a second time at the wrap. Pattern frames longer than eight beats check the 64-byte repeat. Random frames are stalled and reopened to show that the LFSR steps exactly once per accepted beat and never on a start pulse. A start pulse that coincides with a beat request, and setting changes in the middle of a frame, probe the two usual slips: the position advancing past beat 0, and a mode taking effect before its frame has started.

// File: rtl/payload_gen_pkg.sv
package payload_gen_pkg;

  typedef enum logic [1:0] {
    MODE_ZERO = 2'd0,
    MODE_RAND = 2'd1,
    MODE_PAT  = 2'd2,
    MODE_SEQ  = 2'd3
  } modeE;

  typedef struct packed {
    logic clear;    // frame opened: restart positions
    logic advance;  // beat consumed: step positions and LFSR
  } strobeS;

  localparam int SERIAL_BITS  = 32;
  localparam int SERIAL_BYTES = SERIAL_BITS / 8;

endpackage

// File: rtl/payload_gen_ctrl.sv
module payload_gen_ctrl
  import payload_gen_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sopPulse,
  input  logic                   beatReq,
  input  logic [1:0]             modeSel,
  input  logic                   serialEn,
  input  logic [SERIAL_BITS-1:0] serialVal,
  output strobeS                 strobe,
  output modeE                   curMode,
  output logic                   stampOn,
  output logic [SERIAL_BITS-1:0] curSerial,
  output logic                   firstBeat,
  output logic [IDX_W-1:0]       beatIdx
);

  always_comb begin
    strobe.clear   = sopPulse;
    strobe.advance = beatReq & ~sopPulse;
  end

  // Frame settings: captured only when a frame opens
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode   <= MODE_ZERO;
      stampOn   <= 1'b0;
      curSerial <= '0;
    end else if (strobe.clear) begin
      curMode   <= modeE'(modeSel);
      stampOn   <= serialEn;
      curSerial <= serialVal;
    end
  end

  // Beat position; wraps naturally at the sequence span.
  // firstBeat is kept apart so a wrap back to index 0 is not re-stamped.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatIdx   <= '0;
      firstBeat <= 1'b0;
    end else if (strobe.clear) begin
      beatIdx   <= '0;
      firstBeat <= 1'b1;
    end else if (strobe.advance) begin
      beatIdx   <= beatIdx + 1'b1;
      firstBeat <= 1'b0;
    end
  end

endmodule

// File: rtl/payload_gen_dp.sv
module payload_gen_dp
  import payload_gen_pkg::*;
#(
  parameter int          BEAT_BYTES = 8,
  parameter int          PAT_BYTES  = 64,
  parameter int          IDX_W      = 5,
  parameter logic [63:0] LFSR_SEED  = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] LFSR_TAPS  = 64'hD800_0000_0000_0000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobeS                    strobe,
  input  modeE                      curMode,
  input  logic                      stampOn,
  input  logic [SERIAL_BITS-1:0]    curSerial,
  input  logic                      firstBeat,
  input  logic [IDX_W-1:0]          beatIdx,
  input  logic                      patWrEn,
  input  logic [$clog2(PAT_BYTES)-1:0] patWrAddr,
  input  logic [7:0]                patWrData,
  output logic [BEAT_BYTES*8-1:0]   lfsrState,
  output logic [BEAT_BYTES*8-1:0]   payloadWord
);

  localparam int DATA_W = BEAT_BYTES * 8;
  localparam int LANE_W = $clog2(BEAT_BYTES);
  localparam int PAT_AW = $clog2(PAT_BYTES);

  // Pattern store, byte-wide writes, eight parallel byte reads per beat
  logic [7:0] patMem [PAT_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAT_BYTES; i++) patMem[i] <= '0;
    end else if (patWrEn) begin
      patMem[patWrAddr] <= patWrData;
    end
  end

  // Free-running LFSR: steps on consumed beats only, never reseeded by a frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrState <= LFSR_SEED[DATA_W-1:0];
    end else if (strobe.advance) begin
      lfsrState <= {lfsrState[DATA_W-2:0], ^(lfsrState & LFSR_TAPS[DATA_W-1:0])};
    end
  end

  for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_lane
    logic [IDX_W+LANE_W-1:0] laneOffs;
    logic [7:0]              baseByte;
    logic [7:0]              laneByte;

    assign laneOffs = {beatIdx, LANE_W'(k)};

    always_comb begin
      unique case (curMode)
        MODE_ZERO: baseByte = 8'h00;
        MODE_RAND: baseByte = lfsrState[8*k +: 8];
        MODE_PAT:  baseByte = patMem[laneOffs[PAT_AW-1:0]];
        MODE_SEQ:  baseByte = 8'(laneOffs);
        default:   baseByte = 8'h00;
      endcase
    end

    if (k < SERIAL_BYTES) begin : g_stamp
      assign laneByte = (stampOn && firstBeat)
                      ? curSerial[8*(SERIAL_BYTES-1-k) +: 8] : baseByte;
    end else begin : g_plain
      assign laneByte = baseByte;
    end

    assign payloadWord[8*k +: 8] = laneByte;
  end

endmodule

// File: rtl/payload_gen.sv
module payload_gen
  import payload_gen_pkg::*;
#(
  parameter int          BEAT_BYTES = 8,
  parameter int          PAT_BYTES  = 64,
  parameter int          SEQ_SPAN   = 256,
  parameter logic [63:0] LFSR_SEED  = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] LFSR_TAPS  = 64'hD800_0000_0000_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sopPulse,
  input  logic        beatReq,
  input  logic [1:0]  modeSel,
  input  logic        serialEn,
  input  logic [31:0] serialVal,
  input  logic        patWrEn,
  input  logic [5:0]  patWrAddr,
  input  logic [7:0]  patWrData,
  output logic [63:0] payloadWord
);

  localparam int DATA_W = BEAT_BYTES * 8;
  localparam int LANE_W = $clog2(BEAT_BYTES);
  localparam int IDX_W  = $clog2(SEQ_SPAN) - LANE_W;

  strobeS                 strobe;
  modeE                   curMode;
  logic                   stampOn;
  logic [SERIAL_BITS-1:0] curSerial;
  logic                   firstBeat;
  logic [IDX_W-1:0]       beatIdx;
  logic [DATA_W-1:0]      lfsrState;

  payload_gen_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sopPulse  (sopPulse),
    .beatReq   (beatReq),
    .modeSel   (modeSel),
    .serialEn  (serialEn),
    .serialVal (serialVal),
    .strobe    (strobe),
    .curMode   (curMode),
    .stampOn   (stampOn),
    .curSerial (curSerial),
    .firstBeat (firstBeat),
    .beatIdx   (beatIdx)
  );

  payload_gen_dp #(
    .BEAT_BYTES (BEAT_BYTES),
    .PAT_BYTES  (PAT_BYTES),
    .IDX_W      (IDX_W),
    .LFSR_SEED  (LFSR_SEED),
    .LFSR_TAPS  (LFSR_TAPS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .curMode     (curMode),
    .stampOn     (stampOn),
    .curSerial   (curSerial),
    .firstBeat   (firstBeat),
    .beatIdx     (beatIdx),
    .patWrEn     (patWrEn),
    .patWrAddr   (patWrAddr),
    .patWrData   (patWrData),
    .lfsrState   (lfsrState),
    .payloadWord (payloadWord)
  );

endmodule

// File: rtl/payload_gen_chk.sv
module payload_gen_chk
  import payload_gen_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   sopPulse,
  input logic                   beatReq,
  input logic                   patWrEn,
  input logic [63:0]            payloadWord,
  input modeE                   curMode,
  input logic                   stampOn,
  input logic [SERIAL_BITS-1:0] curSerial,
  input logic                   firstBeat,
  input logic [IDX_W-1:0]       beatIdx,
  input logic [63:0]            lfsrState
);

  // R2
  zero_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_ZERO && !stampOn) |-> payloadWord == 64'd0);

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != 64'd0);

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_SEQ && !(stampOn && firstBeat))
      |-> payloadWord[15:8] == 8'(payloadWord[7:0] + 8'd1));

  // R6
  stamp_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stampOn && firstBeat) |-> (payloadWord[7:0] == curSerial[31:24] &&
                                payloadWord[31:24] == curSerial[7:0]));

  // R7
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sopPulse |=> ($stable(curMode) && $stable(stampOn) && $stable(curSerial)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sopPulse && !beatReq && !patWrEn)
      |=> ($stable(payloadWord) && $stable(lfsrState) && $stable(beatIdx)));

  // R9
  sop_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    sopPulse |=> (firstBeat && beatIdx == '0));

endmodule

bind payload_gen payload_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sopPulse    (sopPulse),
  .beatReq     (beatReq),
  .patWrEn     (patWrEn),
  .payloadWord (payloadWord),
  .curMode     (curMode),
  .stampOn     (stampOn),
  .curSerial   (curSerial),
  .firstBeat   (firstBeat),
  .beatIdx     (beatIdx),
  .lfsrState   (lfsrState)
);

// File: tb/payload_gen_bench.sv
module payload_gen_bench;

  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] SEED = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] TAPS = 64'hD800_0000_0000_0000;

  // {mode[1:0], stamp, serial[31:0], beats[5:0]}
  localparam int NVEC = 7;
  localparam logic [40:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 32'h0000_0000, 6'd3},
    {2'd1, 1'b0, 32'h0000_0000, 6'd5},
    {2'd2, 1'b1, 32'hA1B2_C3D4, 6'd10},
    {2'd3, 1'b0, 32'h0000_0000, 6'd34},
    {2'd3, 1'b1, 32'h0102_0304, 6'd34},
    {2'd1, 1'b1, 32'hDEAD_BEEF, 6'd4},
    {2'd0, 1'b1, 32'hCAFE_F00D, 6'd2}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        sopPulse, beatReq, serialEn, patWrEn;
  logic [1:0]  modeSel;
  logic [31:0] serialVal;
  logic [5:0]  patWrAddr;
  logic [7:0]  patWrData;
  logic [63:0] payloadWord;

  payload_gen u_payload_gen (
    .clk(clk), .rstN(rstN), .sopPulse(sopPulse), .beatReq(beatReq),
    .modeSel(modeSel), .serialEn(serialEn), .serialVal(serialVal),
    .patWrEn(patWrEn), .patWrAddr(patWrAddr), .patWrData(patWrData),
    .payloadWord(payloadWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          nChecks = 0;
  int          nFails  = 0;
  bit          finished = 1'b0;
  logic [63:0] lfsrM;
  logic [7:0]  patM [64];
  int          fMode;
  bit          fStamp;
  logic [31:0] fSerial;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock, tracking the reference state at the edge
  task automatic step();
    @(posedge clk);
    if (rstN && beatReq && !sopPulse) lfsrM = {lfsrM[62:0], ^(lfsrM & TAPS)};
    if (rstN && patWrEn) patM[patWrAddr] = patWrData;
    if (!rstN) lfsrM = SEED;
    @(negedge clk);
  endtask

  function automatic logic [63:0] expWord(input int b);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) begin
      int p = b * 8 + k;
      logic [7:0] v;
      case (fMode)
        1: v = lfsrM[8*k +: 8];
        2: v = patM[p % 64];
        3: v = 8'(p % 256);
        default: v = 8'h00;
      endcase
      if (fStamp && b == 0 && k < 4) v = fSerial[8*(3-k) +: 8];
      w[8*k +: 8] = v;
    end
    return w;
  endfunction

  task automatic openFrame(input int m, input bit st, input logic [31:0] ser, input bit withReq);
    sopPulse = 1'b1; beatReq = withReq; modeSel = 2'(m); serialEn = st; serialVal = ser;
    step();
    sopPulse = 1'b0; beatReq = 1'b0;
    fMode = m; fStamp = st; fSerial = ser;
  endtask

  function automatic string reqOf(input int m, input bit st, input int b);
    if (st && b == 0) return "R6";
    case (m)
      1: return "R3";
      2: return "R4";
      3: return (b >= 32) ? "R5 wrap" : "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    rstN = 1'b0; sopPulse = 0; beatReq = 0; modeSel = 0; serialEn = 0;
    serialVal = 0; patWrEn = 0; patWrAddr = 0; patWrData = 0;
    lfsrM = SEED;
    for (int i = 0; i < 64; i++) patM[i] = 8'h00;
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1: reset state
    check("R1 reset word", payloadWord, 64'd0);

    // R1: cleared pattern store reads zero
    openFrame(2, 1'b0, 32'd0, 1'b0);
    check("R1 cleared pattern", payloadWord, 64'd0);

    // R10: load the pattern store
    for (int i = 0; i < 64; i++) begin
      patWrEn = 1'b1; patWrAddr = 6'(i); patWrData = 8'(i * 29 + 7);
      step();
    end
    patWrEn = 1'b0;
    check("R10 pattern loaded", payloadWord, expWord(0));

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      int nb = int'(VEC[v][5:0]);
      openFrame(int'(VEC[v][40:39]), VEC[v][38], VEC[v][37:6], 1'b0);
      for (int b = 0; b < nb; b++) begin
        check(reqOf(fMode, fStamp, b), payloadWord, expWord(b));
        beatReq = 1'b1;
        step();
      end
      beatReq = 1'b0;
    end

    // R8: stall in random mode holds word and LFSR
    openFrame(1, 1'b0, 32'd0, 1'b0);
    beatReq = 1'b1; step(); step(); beatReq = 1'b0;
    for (int s = 0; s < 3; s++) begin
      check("R8 stall hold", payloadWord, expWord(2));
      step();
    end
    beatReq = 1'b1; step(); beatReq = 1'b0;
    check("R8 resume", payloadWord, expWord(3));

    // R7: mid-frame setting changes ignored
    openFrame(2, 1'b0, 32'd0, 1'b0);
    modeSel = 2'd3; serialEn = 1'b1; serialVal = 32'hFFFF_FFFF;
    check("R7 beat0", payloadWord, expWord(0));
    beatReq = 1'b1; step(); beatReq = 1'b0;
    check("R7 beat1", payloadWord, expWord(1));

    // R10: mid-frame write visible next cycle (beat 1, lane 1 = address 9)
    patWrEn = 1'b1; patWrAddr = 6'd9; patWrData = 8'h5A;
    step();
    patWrEn = 1'b0;
    check("R10 live write", payloadWord, expWord(1));
    check("R10 lane byte", {56'd0, payloadWord[15:8]}, 64'h5A);

    // R9: start pulse with a beat request in the same cycle (random mode)
    beatReq = 1'b1; step(); step(); beatReq = 1'b0;
    openFrame(1, 1'b1, 32'h1234_5678, 1'b1);
    check("R9 sop priority", payloadWord, expWord(0));
    beatReq = 1'b1; step(); beatReq = 1'b0;
    check("R9 after sop", payloadWord, expWord(1));

    // R9: restart mid-frame in sequence mode
    openFrame(3, 1'b0, 32'd0, 1'b0);
    beatReq = 1'b1; repeat (5) step(); beatReq = 1'b0;
    openFrame(3, 1'b0, 32'd0, 1'b1);
    check("R9 seq restart", payloadWord, expWord(0));

    finish();
  end

endmodule